// File: doc/BRIEF.md
# Multichannel Audio Sample FIFO

This block buffers audio samples for one direction of a serial audio port. In playback form the CPU writes 24-bit words through a small register window and the serial side takes one word per channel slot. In capture form the serial side deposits one word per slot and the CPU reads the words out. One RAM holds the words. The space is split among the active channels in power-of-two groups, so the number of frames that fit falls as the channel count rises.

A control register empties the FIFO in one cycle and enables a level request at the half-capacity point. A status register reports how many complete frames are stored, and keeps sticky flags for overrun and underrun. The direction is fixed by a parameter. The RAM size is a 3-bit size parameter that scales a 256-word base.

Top module: `chan_sample_fifo`

## Requirements
- R1: After reset the status register reads zero, the control register reads zero and `dataReq` is low.
- R2: The frame capacity is (256 << SIZE_CODE) halved once for each doubling needed to reach the channel count. With a 256-word RAM, 1 channel holds 256 frames, 2 channels hold 128, 3 or 4 hold 64, and 5 to 8 hold 32. A `chanCount` of 0 acts as 1, and a count above 8 acts as 8.
- R3: Words leave in the order they entered, with all 24 bits intact, so a 16-bit sample placed in bits 23:8 comes out unchanged. Bits 31:24 of a data write are ignored, and bits 31:24 of a data read are zero.
- R4: Status bits 16:8 hold the number of complete frames stored. A partly written frame is not counted, and the count saturates at 511.
- R5: A producer word that arrives while the FIFO holds full capacity is discarded and sets the overrun flag, status bit 4.
- R6: A consumer pop while no complete frame is stored returns zero, leaves the FIFO unchanged and sets the underrun flag, status bit 0.
- R7: Both flags stay set until a status write clears them. Each flag is cleared where the written bit (4 or 0) is 0 and kept where it is 1.
- R8: Writing control bit 0 as 1 empties the FIFO within the same cycle (fill reads 0 after that edge). The bit reads back as 0, and the flags are left unchanged.
- R9: In playback form, `dataReq` is high when the half enable (control bit 20) is set and the frame fill is at or below half capacity.
- R10: In capture form, `dataReq` is high when the half enable is set and the frame fill is at or above half capacity.
- R11: In playback form, data-register writes push and serial strobes pop, and a CPU data read returns zero without popping. In capture form, serial strobes push, CPU data reads pop, and CPU data writes have no effect.
- R12: Register select 0 is data, 1 is control and 2 is status. Control bit 20 reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| chanCount | input | 4 | Active channels per frame, 1 to 8; change only while the FIFO is empty |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; a data read pops at the edge |
| regAddr | input | 2 | Register select: 0 data, 1 control, 2 status |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, valid in the cycle of `regRdEn` |
| serStrobe | input | 1 | Serial-side slot strobe, one word per channel slot |
| serDataIn | input | 24 | Serial-side word pushed in capture form |
| serDataOut | output | 24 | Head word offered to the serial side in playback form |
| dataReq | output | 1 | Level request at the half-capacity point |

## Verification
The assertions check, on every cycle, that no push is ever issued into a full FIFO and no pop from an empty one. They also check that the frame fill never exceeds the capacity for the channel count, that a clear leaves the fill at zero, and that the overrun and underrun flags hold until a status write. Several things can only be shown by the directed scenarios: word ordering, the exact capacity for each channel grouping, the place where a partial frame starts to be counted, the request threshold in each direction, and the way the wrong-side accesses are ignored.

// File: rtl/csf_pkg.sv
package csf_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifoStrobe_t;

  localparam int CTRL_CLEAR_BIT  = 0;
  localparam int CTRL_HALF_IE    = 20;
  localparam int STAT_UNDER_BIT  = 0;
  localparam int STAT_OVER_BIT   = 4;
  localparam int FILL_FIELD_W    = 9;
endpackage

// File: rtl/csf_geometry.sv
module csf_geometry #(
  parameter int BASE_AW = 8,
  parameter int FW      = BASE_AW + 1
) (
  input  logic [3:0]    chanCount,
  output logic [1:0]    groupShift,
  output logic [2:0]    slotLast,
  output logic [FW-1:0] maxFrames,
  output logic [FW-1:0] halfFrames
);
  logic [3:0] effChan;

  always_comb begin
    if (chanCount == 4'd0)      effChan = 4'd1;
    else if (chanCount > 4'd8)  effChan = 4'd8;
    else                        effChan = chanCount;
  end

  always_comb begin
    case (effChan)
      4'd1:          groupShift = 2'd0;
      4'd2:          groupShift = 2'd1;
      4'd3, 4'd4:    groupShift = 2'd2;
      default:       groupShift = 2'd3;
    endcase
  end

  assign slotLast   = 3'(effChan - 4'd1);
  assign maxFrames  = (FW'(1) << BASE_AW) >> groupShift;
  assign halfFrames = maxFrames >> 1;
endmodule

// File: rtl/csf_datapath.sv
module csf_datapath
  import csf_pkg::*;
#(
  parameter int BASE_AW = 8,
  parameter int FW      = BASE_AW + 1,
  parameter int DW      = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobe_t   strb,
  input  logic [DW-1:0] pushData,
  input  logic [1:0]    groupShift,
  input  logic [2:0]    slotLast,
  input  logic [FW-1:0] maxFrames,
  output logic [DW-1:0] headWord,
  output logic [FW-1:0] fillFrames,
  output logic          isFull,
  output logic          isEmpty
);
  localparam int DEPTH = 1 << BASE_AW;

  logic [DW-1:0] mem [DEPTH];
  logic [FW-1:0] wrFrame, rdFrame;
  logic [2:0]    wrSlot, rdSlot;
  logic [FW-1:0] frameMask, wrLine, rdLine;
  logic [BASE_AW-1:0] wrAddr, rdAddr;

  assign frameMask = maxFrames - FW'(1);
  assign wrLine    = ((wrFrame & frameMask) << groupShift) | FW'(wrSlot);
  assign rdLine    = ((rdFrame & frameMask) << groupShift) | FW'(rdSlot);
  assign wrAddr    = wrLine[BASE_AW-1:0];
  assign rdAddr    = rdLine[BASE_AW-1:0];

  assign fillFrames = wrFrame - rdFrame;
  assign isFull     = (fillFrames >= maxFrames);
  assign isEmpty    = (fillFrames == '0);
  assign headWord   = isEmpty ? '0 : mem[rdAddr];

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrAddr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrFrame <= '0;
      rdFrame <= '0;
      wrSlot  <= '0;
      rdSlot  <= '0;
    end else if (strb.clear) begin
      wrFrame <= '0;
      rdFrame <= '0;
      wrSlot  <= '0;
      rdSlot  <= '0;
    end else begin
      if (strb.push) begin
        if (wrSlot == slotLast) begin
          wrSlot  <= '0;
          wrFrame <= wrFrame + FW'(1);
        end else begin
          wrSlot <= wrSlot + 3'd1;
        end
      end
      if (strb.pop) begin
        if (rdSlot == slotLast) begin
          rdSlot  <= '0;
          rdFrame <= rdFrame + FW'(1);
        end else begin
          rdSlot <= rdSlot + 3'd1;
        end
      end
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> !isFull);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !isEmpty);
  assert_fill_bounded_R2: assert property (@(posedge clk) disable iff (!rstN)
    fillFrames <= maxFrames);
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (fillFrames == '0));
endmodule

// File: rtl/csf_control.sv
module csf_control
  import csf_pkg::*;
#(
  parameter bit PLAYBACK = 1'b1,
  parameter int FW       = 9,
  parameter int DW       = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [1:0]    regAddr,
  input  logic [31:0]   regWrData,
  output logic [31:0]   regRdData,
  input  logic          serStrobe,
  input  logic [DW-1:0] serDataIn,
  output logic [DW-1:0] serDataOut,
  output logic          dataReq,
  input  logic [FW-1:0] fillFrames,
  input  logic [FW-1:0] halfFrames,
  input  logic          isFull,
  input  logic          isEmpty,
  input  logic [DW-1:0] headWord,
  output fifoStrobe_t   strb,
  output logic [DW-1:0] pushData
);
  logic prodReq, consReq, reqCond;
  logic [DW-1:0] cpuWord;
  logic clearReq, ctrlWr, statWr;
  logic irqEn, ovrFlag, undFlag;
  logic [FILL_FIELD_W-1:0] fillField;
  logic unusedBits;

  assign unusedBits = ^{regWrData, serDataIn};

  generate
    if (PLAYBACK) begin : g_play
      assign prodReq    = regWrEn && (regAddr == REG_DATA);
      assign consReq    = serStrobe;
      assign pushData   = regWrData[DW-1:0];
      assign reqCond    = (fillFrames <= halfFrames);
      assign cpuWord    = '0;
      assign serDataOut = headWord;
    end else begin : g_cap
      assign prodReq    = serStrobe;
      assign consReq    = regRdEn && (regAddr == REG_DATA);
      assign pushData   = serDataIn;
      assign reqCond    = (fillFrames >= halfFrames);
      assign cpuWord    = headWord;
      assign serDataOut = '0;
    end
  endgenerate

  assign ctrlWr   = regWrEn && (regAddr == REG_CTRL);
  assign statWr   = regWrEn && (regAddr == REG_STAT);
  assign clearReq = ctrlWr && regWrData[CTRL_CLEAR_BIT];

  assign strb.clear = clearReq;
  assign strb.push  = prodReq && !isFull && !clearReq;
  assign strb.pop   = consReq && !isEmpty && !clearReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn   <= 1'b0;
      ovrFlag <= 1'b0;
      undFlag <= 1'b0;
    end else begin
      if (ctrlWr) irqEn <= regWrData[CTRL_HALF_IE];
      if (statWr) begin
        ovrFlag <= ovrFlag & regWrData[STAT_OVER_BIT];
        undFlag <= undFlag & regWrData[STAT_UNDER_BIT];
      end
      if (prodReq && isFull && !clearReq)  ovrFlag <= 1'b1;
      if (consReq && isEmpty && !clearReq) undFlag <= 1'b1;
    end
  end

  assign fillField = (fillFrames > FW'(511)) ? 9'h1FF : fillFrames[8:0];
  assign dataReq   = irqEn && reqCond;

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      case (regAddr)
        REG_DATA: regRdData = {8'h00, cpuWord};
        REG_CTRL: regRdData = {11'd0, irqEn, 20'd0};
        REG_STAT: regRdData = {15'd0, fillField, 3'd0, ovrFlag, 3'd0, undFlag};
        default:  regRdData = '0;
      endcase
    end
  end

  assert_over_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ovrFlag && !statWr) |=> ovrFlag);
  assert_under_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (undFlag && !statWr) |=> undFlag);
endmodule

// File: rtl/chan_sample_fifo.sv
module chan_sample_fifo
  import csf_pkg::*;
#(
  parameter int SIZE_CODE = 0,
  parameter bit PLAYBACK  = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  chanCount,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        serStrobe,
  input  logic [23:0] serDataIn,
  output logic [23:0] serDataOut,
  output logic        dataReq
);
  localparam int DW      = 24;
  localparam int BASE_AW = 8 + SIZE_CODE;
  localparam int FW      = BASE_AW + 1;

  fifoStrobe_t   strb;
  logic [DW-1:0] pushData, headWord;
  logic [FW-1:0] fillFrames, maxFrames, halfFrames;
  logic [1:0]    groupShift;
  logic [2:0]    slotLast;
  logic          isFull, isEmpty;

  csf_geometry #(.BASE_AW(BASE_AW), .FW(FW)) u_geom (
    .chanCount(chanCount), .groupShift(groupShift), .slotLast(slotLast),
    .maxFrames(maxFrames), .halfFrames(halfFrames));

  csf_datapath #(.BASE_AW(BASE_AW), .FW(FW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pushData(pushData),
    .groupShift(groupShift), .slotLast(slotLast), .maxFrames(maxFrames),
    .headWord(headWord), .fillFrames(fillFrames), .isFull(isFull),
    .isEmpty(isEmpty));

  csf_control #(.PLAYBACK(PLAYBACK), .FW(FW), .DW(DW)) u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .serStrobe(serStrobe), .serDataIn(serDataIn), .serDataOut(serDataOut),
    .dataReq(dataReq), .fillFrames(fillFrames), .halfFrames(halfFrames),
    .isFull(isFull), .isEmpty(isEmpty), .headWord(headWord),
    .strb(strb), .pushData(pushData));
endmodule

// File: tb/chan_sample_fifo_tb.sv
`timescale 1ns/1ps
module chan_sample_fifo_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]  pChan = 4'd1, cChan = 4'd1;
  logic        pWrEn = 0, pRdEn = 0, pSer = 0, cWrEn = 0, cRdEn = 0, cSer = 0;
  logic [1:0]  pAddr = 0, cAddr = 0;
  logic [31:0] pWrData = 0, cWrData = 0, pRdData, cRdData;
  logic [23:0] pSerIn = 0, cSerIn = 0, pSerOut, cSerOut;
  logic        pReq, cReq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  chan_sample_fifo #(.SIZE_CODE(0), .PLAYBACK(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .chanCount(pChan), .regWrEn(pWrEn), .regRdEn(pRdEn),
    .regAddr(pAddr), .regWrData(pWrData), .regRdData(pRdData), .serStrobe(pSer),
    .serDataIn(pSerIn), .serDataOut(pSerOut), .dataReq(pReq));

  chan_sample_fifo #(.SIZE_CODE(0), .PLAYBACK(1'b0)) u_dutCap (
    .clk(clk), .rstN(rstN), .chanCount(cChan), .regWrEn(cWrEn), .regRdEn(cRdEn),
    .regAddr(cAddr), .regWrData(cWrData), .regRdData(cRdData), .serStrobe(cSer),
    .serDataIn(cSerIn), .serDataOut(cSerOut), .dataReq(cReq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWr(input bit cap, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    if (cap) begin cWrEn = 1; cAddr = a; cWrData = d; end
    else     begin pWrEn = 1; pAddr = a; pWrData = d; end
    @(negedge clk);
    cWrEn = 0; pWrEn = 0;
  endtask

  task automatic busRd(input bit cap, input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    if (cap) begin cRdEn = 1; cAddr = a; end
    else     begin pRdEn = 1; pAddr = a; end
    #1 d = cap ? cRdData : pRdData;
    @(negedge clk);
    cRdEn = 0; pRdEn = 0;
  endtask

  task automatic serStep(input bit cap, input logic [23:0] din, output logic [23:0] dout);
    @(negedge clk);
    if (cap) begin cSer = 1; cSerIn = din; end
    else     pSer = 1;
    #1 dout = cap ? cSerOut : pSerOut;
    @(negedge clk);
    cSer = 0; pSer = 0;
  endtask

  task automatic readStat(input bit cap, output logic [8:0] fill, output logic ovr, output logic und);
    logic [31:0] s;
    busRd(cap, 2'd2, s);
    fill = s[16:8]; ovr = s[4]; und = s[0];
  endtask

  task automatic tReset();
    logic [31:0] d;
    busRd(0, 2'd2, d); chk("R1 playback status", d, 0);
    busRd(1, 2'd2, d); chk("R1 capture status", d, 0);
    busRd(0, 2'd1, d); chk("R1 R12 control reads zero", d, 0);
    chk("R1 playback req low", pReq, 0);
    chk("R1 capture req low", cReq, 0);
  endtask

  task automatic tOrder();
    logic [23:0] o; logic [31:0] d; logic [8:0] f; logic ov, un;
    for (int i = 0; i < 5; i++) busWr(0, 2'd0, 32'hAB000000 | {8'h00, 16'hBE00 + 16'(i), 8'h00});
    readStat(0, f, ov, un); chk("R4 fill after five words", f, 5);
    for (int i = 0; i < 5; i++) begin
      serStep(0, 0, o);
      chk("R3 order and width", o, {16'hBE00 + 16'(i), 8'h00});
    end
    busWr(0, 2'd0, 32'h00123456);
    busRd(0, 2'd0, d); chk("R11 playback data read returns zero", d, 0);
    readStat(0, f, ov, un); chk("R11 playback data read does not pop", f, 1);
    serStep(0, 0, o); chk("R3 word after ignored read", o, 24'h123456);
  endtask

  task automatic tFullPlay();
    logic [23:0] o; logic [8:0] f; logic ov, un;
    for (int i = 0; i < 256; i++) busWr(0, 2'd0, 32'(i + 24'h100));
    readStat(0, f, ov, un);
    chk("R2 one channel holds 256", f, 256); chk("R5 no overrun yet", ov, 0);
    busWr(0, 2'd0, 32'h00FFFFFF);
    readStat(0, f, ov, un);
    chk("R5 overrun set", ov, 1); chk("R5 fill unchanged", f, 256);
    for (int i = 0; i < 256; i++) begin
      serStep(0, 0, o);
      if (o !== 24'(i + 24'h100)) chk("R5 drained word", o, 24'(i + 24'h100));
    end
    checks++;
    serStep(0, 0, o); chk("R6 empty pop returns zero", o, 0);
    readStat(0, f, ov, un);
    chk("R6 underrun set", un, 1); chk("R7 overrun still held", ov, 1);
    busWr(0, 2'd2, 32'h00000010);
    readStat(0, f, ov, un);
    chk("R7 written one keeps overrun", ov, 1); chk("R7 written zero clears underrun", un, 0);
    busWr(0, 2'd2, 32'h0);
    readStat(0, f, ov, un); chk("R7 zero write clears overrun", ov, 0);
  endtask

  task automatic tGroups();
    logic [8:0] f; logic ov, un; logic [31:0] d;
    logic [3:0] chans [5] = '{4'd2, 4'd3, 4'd5, 4'd0, 4'd9};
    int caps [5] = '{128, 64, 32, 256, 32};
    int words [5] = '{2, 3, 5, 1, 8};
    for (int k = 0; k < 5; k++) begin
      busWr(0, 2'd1, 32'h1);
      @(negedge clk); pChan = chans[k];
      for (int i = 0; i < caps[k] * words[k]; i++) busWr(0, 2'd0, 32'(i));
      readStat(0, f, ov, un); chk($sformatf("R2 capacity chan %0d", chans[k]), f, caps[k]);
      busWr(0, 2'd0, 32'h0);
      readStat(0, f, ov, un); chk("R5 overrun at group capacity", ov, 1);
    end
    busWr(0, 2'd1, 32'h1);
    readStat(0, f, ov, un);
    chk("R8 clear empties", f, 0); chk("R8 clear keeps flags", ov, 1);
    busRd(0, 2'd1, d); chk("R8 clear bit reads zero", d, 0);
    busWr(0, 2'd2, 32'h0);
  endtask

  task automatic tPartial();
    logic [23:0] o; logic [8:0] f; logic ov, un;
    @(negedge clk); pChan = 4'd2;
    busWr(0, 2'd0, 32'h000AAA);
    readStat(0, f, ov, un); chk("R4 partial frame not counted", f, 0);
    serStep(0, 0, o); chk("R6 pop of partial frame returns zero", o, 0);
    readStat(0, f, ov, un); chk("R6 underrun on partial frame", un, 1);
    busWr(0, 2'd0, 32'h000BBB);
    readStat(0, f, ov, un); chk("R4 completed frame counted", f, 1);
    serStep(0, 0, o); chk("R3 first slot", o, 24'h000AAA);
    serStep(0, 0, o); chk("R3 second slot", o, 24'h000BBB);
    busWr(0, 2'd2, 32'h0);
    @(negedge clk); pChan = 4'd1;
  endtask

  task automatic tReqPlay();
    logic [31:0] d; logic [23:0] o;
    busWr(0, 2'd1, 32'h00100001);
    busRd(0, 2'd1, d); chk("R12 half enable reads back", d, 32'h00100000);
    chk("R9 request when empty", pReq, 1);
    for (int i = 0; i < 128; i++) busWr(0, 2'd0, 32'(i));
    chk("R9 request at half", pReq, 1);
    busWr(0, 2'd0, 32'h0);
    chk("R9 request drops above half", pReq, 0);
    busWr(0, 2'd1, 32'h00000001);
    chk("R9 request needs enable", pReq, 0);
    serStep(0, 0, o); chk("R8 nothing left after clear", o, 0);
    busWr(0, 2'd2, 32'h0);
  endtask

  task automatic tCapture();
    logic [31:0] d; logic [23:0] o; logic [8:0] f; logic ov, un;
    busWr(1, 2'd1, 32'h00100000);
    for (int i = 0; i < 127; i++) serStep(1, 24'(i + 24'h5000), o);
    chk("R10 no request below half", cReq, 0);
    serStep(1, 24'(127 + 24'h5000), o);
    chk("R10 request at half", cReq, 1);
    busWr(1, 2'd0, 32'h00777777);
    readStat(1, f, ov, un); chk("R11 capture data write ignored", f, 128);
    for (int i = 0; i < 128; i++) begin
      busRd(1, 2'd0, d);
      if (d !== 32'(i + 24'h5000)) chk("R11 capture read order", d, 32'(i + 24'h5000));
    end
    checks++;
    busRd(1, 2'd0, d); chk("R6 capture empty read zero", d, 0);
    readStat(1, f, ov, un); chk("R6 capture underrun", un, 1);
    for (int i = 0; i < 257; i++) serStep(1, 24'(i), o);
    readStat(1, f, ov, un);
    chk("R5 capture overrun", ov, 1); chk("R2 capture fill full", f, 256);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tOrder();
    tFullPlay();
    tGroups();
    tPartial();
    tReqPlay();
    tCapture();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule